// File: doc/BRIEF.md
# Event-Triggered Pulse Output Stage

This block sits at the output end of a timing receiver. Every event clock cycle it may receive one decoded event code. The code addresses a lookup table written by a host, and the table entry names the pulse generators that the event triggers, forces active, or forces inactive. Each generator divides the event clock by its own prescaler. It then counts a programmable delay, holds its output for a programmable width, and applies a programmable polarity.

Three free-running 16-bit clock dividers produce square waves. A routing stage lets each output pin take any generator, any divider, or any bit of the distributed data bus. The host reaches the lookup table and every setting through one flat write/read port, and read data appears one cycle after the address.

Top module: `evt_pulse_out`

## Requirements
- R1: After reset every pin is low, every routing select is 0 (generator 0), all generator and divider settings are 0, every lookup entry is empty, and host read data is 0.
- R2: Host address bits [9:8] pick the region: 0 is the trigger mask, 1 the force-active mask and 2 the force-inactive mask, with bits [7:0] as the event code and the mask in data bits [11:0]. Region 3 is settings: bits [7:4] give the index and bits [3:0] the field. Indices 0-11 are generators, with field 0 prescale, 1 delay, 2 width and 3 polarity (bit 0). Indices 12-14 are dividers, field 0, 16 bits. Index 15 is routing, where the field is the pin number and data bits [4:0] are the select. Read data is registered, shows the addressed value one cycle after the address, and is 0 for unused fields.
- R3: The actions of a lookup entry take effect only when the event valid input is high. A code whose entry is empty changes nothing.
- R4: With prescale 0 or 1, a trigger sampled at clock edge k makes the generator active from edge k+delay until edge k+delay+width, so it is active for exactly width cycles.
- R5: With prescale P≥2, the delay and width are counted in ticks of P cycles, and the tick phase restarts on the trigger. The output is active from edge k+delay·P for width·P cycles.
- R6: A delay of 0 makes the output active in the cycle right after the triggering event. A width of 0 gives no pulse at all.
- R7: A force-active action makes the output active at the next edge, and a force-inactive action makes it inactive at the next edge. Both cancel any delay or width count in progress.
- R8: When one entry requests several actions on the same generator, force-inactive wins over force-active, and force-active wins over trigger.
- R9: A trigger that arrives while a generator is counting restarts the generator from the new trigger. If the new delay is not zero, the output goes inactive.
- R10: Polarity 1 inverts the generator's level at the pin, so the pin is high at rest and low during the pulse.
- R11: A divider with value D≥2 outputs a square wave with period D that is high for floor(D/2) cycles. A value of 0 or 1 holds it low.
- R12: A routing select of 0-11 picks a generator, 12-14 picks a divider, and 15-22 picks distributed-bus bit (select−15). Selects 23-31 drive the pin low. Routing is combinational from its sources.
- R13: One lookup entry can act on several generators at once, and each uses its own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event code present this cycle |
| evt_code | input | 8 | Decoded event code |
| dbus | input | 8 | Distributed data bus bits |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 10 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after address |
| pin_out | output | 12 | Routed output pins |

## Verification
Generators are driven with single triggers over several delay/width/prescale combinations. These runs separate an off-by-one in the delay count from one in the width count, and a tick phase that restarts on the trigger from one that runs free. Event pairs spaced closer than the delay show restart versus ignore, and show cancel versus late-fire when the second event forces the output inactive. Entries that combine several actions expose the priority order, and entries that mask several generators expose per-generator settings. Walking routing selects across generator, divider, bus and out-of-range values checks each source class, and inverted polarity checks both the rest and pulse levels.

// File: rtl/evt_pulse_pkg.sv
package evt_pulse_pkg;

  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_DELAY = 2'd1,
    GS_WIDTH = 2'd2
  } gen_state_e;

  localparam logic [1:0] RGN_TRIG = 2'd0;
  localparam logic [1:0] RGN_SET  = 2'd1;
  localparam logic [1:0] RGN_CLR  = 2'd2;
  localparam logic [1:0] RGN_CFG  = 2'd3;

  localparam logic [3:0] FLD_PRESC = 4'd0;
  localparam logic [3:0] FLD_DELAY = 4'd1;
  localparam logic [3:0] FLD_WIDTH = 4'd2;
  localparam logic [3:0] FLD_POL   = 4'd3;

endpackage

// File: rtl/evt_map_ram.sv
module evt_map_ram #(
  parameter int NUM_GEN = 12,
  parameter int CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_rgn,
  input  logic [CODE_W-1:0]  wr_code,
  input  logic [NUM_GEN-1:0] wr_mask,
  input  logic [CODE_W-1:0]  lk_code,
  output logic [NUM_GEN-1:0] lk_trig,
  output logic [NUM_GEN-1:0] lk_set,
  output logic [NUM_GEN-1:0] lk_clr,
  input  logic [1:0]         hr_rgn,
  input  logic [CODE_W-1:0]  hr_code,
  output logic [NUM_GEN-1:0] hr_mask
);
  localparam int NUM_CODE = 1 << CODE_W;
  localparam int NUM_RGN  = 3;

  logic [NUM_GEN-1:0] lk_word [NUM_RGN];
  logic [NUM_GEN-1:0] hr_word [NUM_RGN];

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    logic [NUM_GEN-1:0] mem_q [NUM_CODE];
    logic               we_rgn;

    assign we_rgn = wr_en && (wr_rgn == 2'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int c = 0; c < NUM_CODE; c++) mem_q[c] <= '0;
      end else if (we_rgn) begin
        mem_q[wr_code] <= wr_mask;
      end
    end

    assign lk_word[r] = mem_q[lk_code];
    assign hr_word[r] = mem_q[hr_code];
  end

  assign lk_trig = lk_word[0];
  assign lk_set  = lk_word[1];
  assign lk_clr  = lk_word[2];

  always_comb begin
    case (hr_rgn)
      2'd0:    hr_mask = hr_word[0];
      2'd1:    hr_mask = hr_word[1];
      2'd2:    hr_mask = hr_word[2];
      default: hr_mask = '0;
    endcase
  end
endmodule

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_trig,
  input  logic             act_set,
  input  logic             act_clr,
  input  logic [CNT_W-1:0] cfg_presc,
  input  logic [CNT_W-1:0] cfg_delay,
  input  logic [CNT_W-1:0] cfg_width,
  output logic             lvl_o
);
  import evt_pulse_pkg::*;

  gen_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pc_q, pc_d;
  logic             lvl_q, lvl_d;
  logic             tick;

  assign tick = (cfg_presc <= CNT_W'(1)) || (pc_q >= cfg_presc - CNT_W'(1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    pc_d  = pc_q;
    lvl_d = lvl_q;
    if (act_clr) begin
      st_d  = GS_IDLE;
      lvl_d = 1'b0;
    end else if (act_set) begin
      st_d  = GS_IDLE;
      lvl_d = 1'b1;
    end else if (act_trig) begin
      pc_d  = '0;
      lvl_d = (cfg_delay == '0) && (cfg_width != '0);
      if (cfg_delay != '0) begin
        st_d  = GS_DELAY;
        cnt_d = cfg_delay;
      end else if (cfg_width != '0) begin
        st_d  = GS_WIDTH;
        cnt_d = cfg_width;
      end else begin
        st_d  = GS_IDLE;
      end
    end else if (st_q != GS_IDLE) begin
      pc_d = tick ? '0 : pc_q + CNT_W'(1);
      if (tick) begin
        if (cnt_q == CNT_W'(1)) begin
          if (st_q == GS_DELAY && cfg_width != '0) begin
            st_d  = GS_WIDTH;
            cnt_d = cfg_width;
            lvl_d = 1'b1;
          end else begin
            st_d  = GS_IDLE;
            lvl_d = 1'b0;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GS_IDLE;
      cnt_q <= '0;
      pc_q  <= '0;
      lvl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pc_q  <= pc_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/evt_free_div.sv
module evt_free_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             wave_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             run;

  assign run = div > DIV_W'(1);

  always_comb begin
    if (!run || cnt_q >= div - DIV_W'(1)) cnt_d = '0;
    else                                  cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wave_o = run && (cnt_q < (div >> 1));
endmodule

// File: rtl/evt_out_xbar.sv
module evt_out_xbar #(
  parameter int NUM_SRC = 23,
  parameter int NUM_OUT = 12,
  parameter int SEL_W   = 5
) (
  input  logic [NUM_SRC-1:0]            src,
  input  logic [NUM_OUT-1:0][SEL_W-1:0] sel,
  output logic [NUM_OUT-1:0]            pin
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_pin
    assign pin[o] = (sel[o] < SEL_W'(NUM_SRC)) ? src[sel[o]] : 1'b0;
  end
endmodule

// File: rtl/evt_pulse_out.sv
module evt_pulse_out #(
  parameter int NUM_GEN = 12,
  parameter int NUM_DIV = 3,
  parameter int NUM_OUT = 12,
  parameter int DBUS_W  = 8,
  parameter int CODE_W  = 8,
  parameter int CNT_W   = 32,
  parameter int DIV_W   = 16,
  parameter int HOST_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [DBUS_W-1:0] dbus,
  input  logic              host_wr,
  input  logic [CODE_W+1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic [NUM_OUT-1:0] pin_out
);
  import evt_pulse_pkg::*;

  localparam int NUM_SRC = NUM_GEN + NUM_DIV + DBUS_W;
  localparam int SEL_W   = $clog2(NUM_SRC + 1);
  localparam int IDX_W   = CODE_W - 4;
  localparam int IDX_RT  = (1 << IDX_W) - 1;

  logic [1:0]        a_rgn;
  logic [IDX_W-1:0]  a_idx;
  logic [3:0]        a_fld;
  logic              cfg_wr;
  logic              map_wr;

  assign a_rgn  = host_addr[CODE_W+1:CODE_W];
  assign a_idx  = host_addr[CODE_W-1:4];
  assign a_fld  = host_addr[3:0];
  assign cfg_wr = host_wr && (a_rgn == RGN_CFG);
  assign map_wr = host_wr && (a_rgn != RGN_CFG);

  logic [NUM_GEN-1:0][CNT_W-1:0] gen_presc_q, gen_dly_q, gen_wid_q;
  logic [NUM_GEN-1:0]            gen_pol_q;
  logic [NUM_DIV-1:0][DIV_W-1:0] div_q;
  logic [NUM_OUT-1:0][SEL_W-1:0] osel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_presc_q <= '0;
      gen_dly_q   <= '0;
      gen_wid_q   <= '0;
      gen_pol_q   <= '0;
      div_q       <= '0;
      osel_q      <= '0;
    end else if (cfg_wr) begin
      for (int g = 0; g < NUM_GEN; g++) begin
        if (a_idx == IDX_W'(g)) begin
          if (a_fld == FLD_PRESC) gen_presc_q[g] <= host_wdata[CNT_W-1:0];
          if (a_fld == FLD_DELAY) gen_dly_q[g]   <= host_wdata[CNT_W-1:0];
          if (a_fld == FLD_WIDTH) gen_wid_q[g]   <= host_wdata[CNT_W-1:0];
          if (a_fld == FLD_POL)   gen_pol_q[g]   <= host_wdata[0];
        end
      end
      for (int d = 0; d < NUM_DIV; d++) begin
        if (a_idx == IDX_W'(NUM_GEN + d) && a_fld == FLD_PRESC)
          div_q[d] <= host_wdata[DIV_W-1:0];
      end
      for (int o = 0; o < NUM_OUT; o++) begin
        if (a_idx == IDX_W'(IDX_RT) && a_fld == 4'(o))
          osel_q[o] <= host_wdata[SEL_W-1:0];
      end
    end
  end

  logic [NUM_GEN-1:0] lk_trig, lk_set, lk_clr, hr_mask;
  logic [NUM_GEN-1:0] act_trig, act_set, act_rst;

  evt_map_ram #(.NUM_GEN(NUM_GEN), .CODE_W(CODE_W)) map_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_wr),
    .wr_rgn  (a_rgn),
    .wr_code (host_addr[CODE_W-1:0]),
    .wr_mask (host_wdata[NUM_GEN-1:0]),
    .lk_code (evt_code),
    .lk_trig (lk_trig),
    .lk_set  (lk_set),
    .lk_clr  (lk_clr),
    .hr_rgn  (a_rgn),
    .hr_code (host_addr[CODE_W-1:0]),
    .hr_mask (hr_mask)
  );

  assign act_trig = evt_valid ? lk_trig : '0;
  assign act_set  = evt_valid ? lk_set  : '0;
  assign act_rst  = evt_valid ? lk_clr  : '0;

  logic [NUM_GEN-1:0] gen_lvl;
  logic [NUM_DIV-1:0] div_wave;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    evt_pulse_gen #(.CNT_W(CNT_W)) gen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_trig  (act_trig[g]),
      .act_set   (act_set[g]),
      .act_clr   (act_rst[g]),
      .cfg_presc (gen_presc_q[g]),
      .cfg_delay (gen_dly_q[g]),
      .cfg_width (gen_wid_q[g]),
      .lvl_o     (gen_lvl[g])
    );
  end

  for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
    evt_free_div #(.DIV_W(DIV_W)) div_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .div    (div_q[d]),
      .wave_o (div_wave[d])
    );
  end

  logic [NUM_SRC-1:0] xsrc;
  assign xsrc = {dbus, div_wave, gen_lvl ^ gen_pol_q};

  evt_out_xbar #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) xbar_i (
    .src (xsrc),
    .sel (osel_q),
    .pin (pin_out)
  );

  logic [HOST_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    if (a_rgn != RGN_CFG) begin
      rd_d[NUM_GEN-1:0] = hr_mask;
    end else begin
      for (int g = 0; g < NUM_GEN; g++) begin
        if (a_idx == IDX_W'(g)) begin
          case (a_fld)
            FLD_PRESC: rd_d[CNT_W-1:0] = gen_presc_q[g];
            FLD_DELAY: rd_d[CNT_W-1:0] = gen_dly_q[g];
            FLD_WIDTH: rd_d[CNT_W-1:0] = gen_wid_q[g];
            FLD_POL:   rd_d[0]         = gen_pol_q[g];
            default:   rd_d            = '0;
          endcase
        end
      end
      for (int d = 0; d < NUM_DIV; d++) begin
        if (a_idx == IDX_W'(NUM_GEN + d) && a_fld == FLD_PRESC)
          rd_d[DIV_W-1:0] = div_q[d];
      end
      for (int o = 0; o < NUM_OUT; o++) begin
        if (a_idx == IDX_W'(IDX_RT) && a_fld == 4'(o))
          rd_d[SEL_W-1:0] = osel_q[o];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign host_rdata = rd_q;
endmodule

// File: rtl/evt_pulse_out_chk.sv
module evt_pulse_out_chk #(
  parameter int NUM_GEN = 12,
  parameter int CNT_W   = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_GEN-1:0]            act_trig,
  input logic [NUM_GEN-1:0]            act_set,
  input logic [NUM_GEN-1:0]            act_rst,
  input logic [NUM_GEN-1:0]            gen_lvl,
  input logic [NUM_GEN-1:0][CNT_W-1:0] gen_dly_q,
  input logic [NUM_GEN-1:0][CNT_W-1:0] gen_wid_q
);
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    // R7 and R8: force-inactive wins and takes effect at the next edge
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      act_rst[g] |=> !gen_lvl[g]);
    // R7: force-active without force-inactive
    a_r7_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (act_set[g] && !act_rst[g]) |=> gen_lvl[g]);
    // R6: zero delay fires in the next cycle
    a_r6_zero_delay_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (act_trig[g] && !act_set[g] && !act_rst[g] && gen_dly_q[g] == '0 && gen_wid_q[g] != '0)
      |=> gen_lvl[g]);
    // R6: zero width gives no pulse
    a_r6_zero_width_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (act_trig[g] && !act_set[g] && !act_rst[g] && gen_wid_q[g] == '0) |=> !gen_lvl[g]);
    // R9: a trigger with nonzero delay restarts the generator inactive
    a_r9_retrig_rearms: assert property (@(posedge clk) disable iff (!rst_n)
      (act_trig[g] && !act_set[g] && !act_rst[g] && gen_dly_q[g] != '0) |=> !gen_lvl[g]);
  end
endmodule

bind evt_pulse_out evt_pulse_out_chk #(.NUM_GEN(NUM_GEN), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .act_trig  (act_trig),
  .act_set   (act_set),
  .act_rst   (act_rst),
  .gen_lvl   (gen_lvl),
  .gen_dly_q (gen_dly_q),
  .gen_wid_q (gen_wid_q)
);

// File: tb/evt_pulse_out_tb_top.sv
`timescale 1ns/100ps
module evt_pulse_out_tb_top;
  logic        clk;
  logic        rst_n;
  logic        evt_valid;
  logic [7:0]  evt_code;
  logic [7:0]  dbus;
  logic        host_wr;
  logic [9:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [11:0] pin_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic [11:0] tr [32];

  evt_pulse_out dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .dbus(dbus), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pin_out(pin_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pulse(input int s, input int l, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) if (i >= s && i < s + l) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] bits(input int p, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = tr[i][p];
    return v;
  endfunction

  function automatic logic [9:0] map_a(input logic [1:0] rgn, input logic [7:0] code);
    return {rgn, code};
  endfunction

  function automatic logic [9:0] cfg_a(input int idx, input int fld);
    return {2'b11, 4'(idx), 4'(fld)};
  endfunction

  task automatic hw(input logic [9:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [9:0] a, output logic [31:0] d);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic set_gen(input int g, input int pr, input int dl, input int wd, input int pol);
    hw(cfg_a(g, 0), 32'(pr));
    hw(cfg_a(g, 1), 32'(dl));
    hw(cfg_a(g, 2), 32'(wd));
    hw(cfg_a(g, 3), 32'(pol));
  endtask

  task automatic route(input int p, input int s);
    hw(cfg_a(15, p), 32'(s));
  endtask

  task automatic run(input logic [7:0] c1, input logic v1, input logic [7:0] c2,
                     input int gap, input int n);
    evt_code = c1; evt_valid = v1;
    @(negedge clk);
    tr[0] = pin_out; evt_valid = 1'b0;
    for (int i = 1; i < n; i++) begin
      if (i == gap) begin evt_code = c2; evt_valid = 1'b1; end
      @(negedge clk);
      tr[i] = pin_out; evt_valid = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pins after reset", 64'(pin_out), 64'h0);
    chk("R1 rdata after reset", 64'(host_rdata), 64'h0);
    hr(map_a(2'd0, 8'h10), d);
    chk("R1 lookup entry empty", 64'(d), 64'h0);
  endtask

  task automatic t_host();
    logic [31:0] d;
    hw(cfg_a(5, 2), 32'h1234_5678);
    hr(cfg_a(5, 2), d);
    chk("R2 width readback", 64'(d), 64'h1234_5678);
    hw(map_a(2'd0, 8'h21), 32'h0A5);
    hr(map_a(2'd0, 8'h21), d);
    chk("R2 mask readback", 64'(d), 64'h0A5);
    hr(cfg_a(5, 9), d);
    chk("R2 unused field reads 0", 64'(d), 64'h0);
  endtask

  task automatic t_basic();
    hw(map_a(2'd0, 8'h01), 32'h001);
    route(0, 0);
    set_gen(0, 1, 2, 2, 0);
    run(8'h01, 1'b1, 8'h00, -1, 12);
    chk("R4 delay2 width2", bits(0, 12), pulse(2, 2, 12));
    set_gen(0, 0, 0, 3, 0);
    run(8'h01, 1'b1, 8'h00, -1, 12);
    chk("R6 zero delay fires next cycle", bits(0, 12), pulse(0, 3, 12));
    set_gen(0, 0, 1, 0, 0);
    run(8'h01, 1'b1, 8'h00, -1, 12);
    chk("R6 zero width no pulse", bits(0, 12), 64'h0);
  endtask

  task automatic t_presc();
    set_gen(0, 3, 1, 1, 0);
    run(8'h01, 1'b1, 8'h00, -1, 14);
    chk("R5 prescale3 delay1 width1", bits(0, 14), pulse(3, 3, 14));
    set_gen(0, 2, 2, 3, 0);
    run(8'h01, 1'b1, 8'h00, -1, 16);
    chk("R5 prescale2 delay2 width3", bits(0, 16), pulse(4, 6, 16));
  endtask

  task automatic t_valid();
    set_gen(0, 0, 0, 3, 0);
    run(8'h01, 1'b0, 8'h00, -1, 8);
    chk("R3 valid low ignored", bits(0, 8), 64'h0);
    run(8'h99, 1'b1, 8'h00, -1, 8);
    chk("R3 empty entry ignored", bits(0, 8), 64'h0);
  endtask

  task automatic t_setclr();
    hw(map_a(2'd1, 8'h02), 32'h001);
    hw(map_a(2'd2, 8'h03), 32'h001);
    run(8'h02, 1'b1, 8'h00, -1, 6);
    chk("R7 force active", bits(0, 6), pulse(0, 6, 6));
    run(8'h03, 1'b1, 8'h00, -1, 6);
    chk("R7 force inactive", bits(0, 6), 64'h0);
    set_gen(0, 0, 5, 3, 0);
    run(8'h01, 1'b1, 8'h03, 2, 14);
    chk("R7 clear cancels pending delay", bits(0, 14), 64'h0);
  endtask

  task automatic t_prio();
    hw(map_a(2'd1, 8'h04), 32'h001);
    hw(map_a(2'd2, 8'h04), 32'h001);
    run(8'h02, 1'b1, 8'h00, -1, 2);
    run(8'h04, 1'b1, 8'h00, -1, 6);
    chk("R8 clear beats set", bits(0, 6), 64'h0);
    hw(map_a(2'd0, 8'h05), 32'h001);
    hw(map_a(2'd1, 8'h05), 32'h001);
    set_gen(0, 0, 3, 2, 0);
    run(8'h05, 1'b1, 8'h00, -1, 10);
    chk("R8 set beats trigger", bits(0, 10), pulse(0, 10, 10));
    run(8'h03, 1'b1, 8'h00, -1, 2);
  endtask

  task automatic t_retrig();
    set_gen(0, 0, 3, 2, 0);
    run(8'h01, 1'b1, 8'h01, 2, 12);
    chk("R9 retrigger restarts", bits(0, 12), pulse(5, 2, 12));
  endtask

  task automatic t_pol();
    hw(map_a(2'd0, 8'h06), 32'h008);
    route(2, 3);
    set_gen(3, 0, 1, 2, 1);
    chk("R10 inverted rest level", 64'(pin_out[2]), 64'h1);
    run(8'h06, 1'b1, 8'h00, -1, 10);
    chk("R10 inverted pulse", bits(2, 10), ~pulse(1, 2, 10) & 64'h3FF);
  endtask

  task automatic t_multi();
    hw(map_a(2'd0, 8'h07), 32'h006);
    route(4, 1);
    route(5, 2);
    set_gen(1, 0, 0, 2, 0);
    set_gen(2, 0, 3, 1, 0);
    run(8'h07, 1'b1, 8'h00, -1, 8);
    chk("R13 generator 1 from shared entry", bits(4, 8), pulse(0, 2, 8));
    chk("R13 generator 2 from shared entry", bits(5, 8), pulse(3, 1, 8));
  endtask

  task automatic t_div();
    logic [63:0] v;
    hw(cfg_a(12, 0), 32'd4);
    route(1, 12);
    run(8'h00, 1'b0, 8'h00, -1, 3);
    run(8'h00, 1'b0, 8'h00, -1, 8);
    v = bits(1, 8);
    chk("R11 divider 4 duty", 64'($countones(v)), 64'd4);
    chk("R11 divider 4 period", 64'(v[3:0]), 64'(v[7:4]));
    hw(cfg_a(14, 0), 32'd5);
    route(1, 14);
    run(8'h00, 1'b0, 8'h00, -1, 3);
    run(8'h00, 1'b0, 8'h00, -1, 10);
    chk("R11 divider 5 duty", 64'($countones(bits(1, 10))), 64'd4);
    hw(cfg_a(13, 0), 32'd1);
    route(1, 13);
    run(8'h00, 1'b0, 8'h00, -1, 6);
    chk("R11 divider 1 held low", bits(1, 6), 64'h0);
  endtask

  task automatic t_xbar();
    route(3, 20);
    dbus = 8'h20;
    @(negedge clk);
    chk("R12 bus bit 5 high", 64'(pin_out[3]), 64'h1);
    dbus = 8'hDF;
    @(negedge clk);
    chk("R12 bus bit 5 low", 64'(pin_out[3]), 64'h0);
    route(3, 25);
    dbus = 8'hFF;
    @(negedge clk);
    chk("R12 out-of-range select low", 64'(pin_out[3]), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_code = '0; dbus = '0;
    host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host();
    t_basic();
    t_presc();
    t_valid();
    t_setclr();
    t_prio();
    t_retrig();
    t_pol();
    t_multi();
    t_div();
    t_xbar();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule